// File: doc/BRIEF.md
# Multi-Channel Countdown Timer

This block is a memory-mapped timer with four independent countdown channels and one free-running 32-bit up-counter. Software writes a start value into a channel's count register. It then sets that channel's run bit in a single shared control word. The channel counts down on the timebase it has selected and raises its own interrupt line when it expires. After expiry a one-shot channel stops and drops its run bit. A periodic channel reloads its start value and keeps running.

The timebases are 1 µs, 10 µs, 100 µs and 1 ms. All four come from one prescaler chain that is sized from a system-clock frequency parameter. The up-counter has no interrupt. It serves as a timestamp. It can step on every system clock or on any of the four timebases.

The register port is a plain single-cycle write strobe with an address. Reads are combinational from the address. The interrupt lines are levels. Each line stays high until software writes a 1 to that channel's bit in the status register.

Top module: `mc_timer`

## Requirements
- R1: After reset, the control word, the status register, every count register and all four interrupt lines read 0.
- R2: The 1 µs tick comes every CLK_MHZ system cycles. The 10 µs, 100 µs and 1 ms ticks each come ten times less often than the tick before them. A countdown channel with timebase select 0, 1, 2 or 3 steps on the 1 µs, 10 µs, 100 µs or 1 ms tick.
- R3: Channel i (0..3) has its count register at byte offset 0x04+4·i. When a one-shot channel is started with value N, it sets its interrupt after exactly N+1 ticks. At the same time it clears its own run bit, and its count stays at 0.
- R4: A periodic channel loaded with N sets its interrupt every (N+1) ticks. It reloads N at each expiry.
- R5: The status register is at 0x18. Bit i reads the interrupt of channel i. Writing 1 to bit i clears it and writing 0 leaves it unchanged. An expiry that lands in the same cycle as a clear wins, so the interrupt stays set.
- R6: Clearing a run bit freezes that channel's count at once, and the channel raises no interrupt while it is stopped. Setting the run bit again restarts the count from the loaded value.
- R7: The up-counter is at 0x14. It adds one per system cycle when its select is 0 or 5..7. It adds one per 1 µs, 10 µs, 100 µs or 1 ms tick for select 1, 2, 3 or 4. It wraps modulo 2^32.
- R8: Writes to the up-counter offset 0x14 have no effect on its value.
- R9: The control word at 0x00 places its fields as follows: run bits at 16+i, periodic-mode bits at 12+i (1 = periodic), 2-bit countdown timebase selects at [2i+1:2i], and the up-counter select at [10:8]. The unused bits 11 and 31:20 read 0.
- R10: Each channel drives only its own interrupt line, irq[i]. An expiry on one channel leaves the other lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 4 | Per-channel interrupt levels |

## Verification
The hardest case to reach from the ports is a status clear landing on the very cycle in which a periodic channel expires again. The bench first measures the exact period of a periodic channel, which is free of prescaler-phase uncertainty. It then starts the clear write so that the write completes on the next expiry edge, and checks that the line is still high. The one-shot and restart cases do depend on the prescaler phase, so their latencies are checked against a one-tick window.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int N_CH     = 4;
  localparam int N_TB     = 4;
  localparam int TBSEL_W  = 2;
  localparam int ESEL_W   = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CH0  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_UP   = 5'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h18;

  localparam int RUN_LSB  = 16;
  localparam int MODE_LSB = 12;
  localparam int ESEL_LSB = 8;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h000F_F7FF;

  typedef enum logic [TBSEL_W-1:0] {
    TB_US1   = 2'd0,
    TB_US10  = 2'd1,
    TB_US100 = 2'd2,
    TB_MS1   = 2'd3
  } tbase_e;

  function automatic logic [ADDR_W-1:0] ch_offset(input int idx);
    return ADDR_W'(int'(OFF_CH0) + 4 * idx);
  endfunction
endpackage

// File: rtl/mc_tick_gen.sv
module mc_tick_gen #(
  parameter int CLK_MHZ = 100,
  parameter int DECADE  = 10,
  parameter int STAGES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] ticks
);
  localparam int US_W  = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam int DEC_W = $clog2(DECADE);

  logic [US_W-1:0]   us_cnt;
  logic [STAGES-1:0] stage_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) us_cnt <= '0;
    else if (us_cnt == US_W'(CLK_MHZ - 1)) us_cnt <= '0;
    else us_cnt <= us_cnt + 1'b1;
  end

  assign stage_tick[0] = (us_cnt == US_W'(CLK_MHZ - 1));

  for (genvar g = 1; g < STAGES; g++) begin : g_decade
    logic [DEC_W-1:0] dec;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec <= '0;
      else if (stage_tick[g-1]) dec <= (dec == DEC_W'(DECADE - 1)) ? '0 : dec + 1'b1;
    end
    assign stage_tick[g] = stage_tick[g-1] && (dec == DEC_W'(DECADE - 1));
  end

  assign ticks = stage_tick;
endmodule

// File: rtl/mc_down_chan.sv
module mc_down_chan
  import mc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TB-1:0]  ticks,
  input  tbase_e           tb_sel,
  input  logic             run,
  input  logic             periodic,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;

  assign step   = ticks[tb_sel];
  assign expire = run && step && !start && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= load_val;
    end else if (run && step) begin
      if (count == '0) count <= periodic ? load_val : '0;
      else count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/mc_up_counter.sv
module mc_up_counter
  import mc_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TB-1:0]   ticks,
  input  logic [ESEL_W-1:0] sel,
  output logic [W-1:0]      count
);
  logic step;

  always_comb begin
    case (sel)
      3'd1:    step = ticks[0];
      3'd2:    step = ticks[1];
      3'd3:    step = ticks[2];
      3'd4:    step = ticks[3];
      default: step = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (step) count <= count + 1'b1;
  end
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import mc_timer_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int CNT_W   = 16,
  parameter int UP_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_CH-1:0]   irq
);
  logic [DATA_W-1:0]    ctrl_q, ctrl_d;
  logic [N_CH-1:0]      irq_q;
  logic [N_TB-1:0]      ticks;
  logic [N_CH-1:0]      start, expire, load_wr;
  logic [CNT_W-1:0]     load_q  [N_CH];
  logic [CNT_W-1:0]     count_w [N_CH];
  logic [N_CH*CNT_W-1:0] count_flat;
  logic [UP_W-1:0]      up_count;
  logic                 ctrl_wr, stat_wr;
  logic [N_CH-1:0]      clr_mask;

  assign ctrl_wr  = reg_wr && (reg_addr == OFF_CTRL);
  assign stat_wr  = reg_wr && (reg_addr == OFF_STAT);
  assign clr_mask = stat_wr ? reg_wdata[N_CH-1:0] : '0;

  mc_tick_gen #(.CLK_MHZ(CLK_MHZ), .DECADE(10), .STAGES(N_TB)) u_ticks (
    .clk  (clk),
    .rst_n(rst_n),
    .ticks(ticks)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_chan
    assign load_wr[i] = reg_wr && (reg_addr == ch_offset(i));
    assign start[i]   = ctrl_wr && reg_wdata[RUN_LSB+i] && !ctrl_q[RUN_LSB+i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q[i] <= '0;
      else if (load_wr[i]) load_q[i] <= reg_wdata[CNT_W-1:0];
    end

    mc_down_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ticks   (ticks),
      .tb_sel  (tbase_e'(ctrl_q[2*i +: TBSEL_W])),
      .run     (ctrl_q[RUN_LSB+i]),
      .periodic(ctrl_q[MODE_LSB+i]),
      .start   (start[i]),
      .load_val(load_q[i]),
      .count   (count_w[i]),
      .expire  (expire[i])
    );

    assign count_flat[i*CNT_W +: CNT_W] = count_w[i];
  end

  mc_up_counter #(.W(UP_W)) u_up (
    .clk  (clk),
    .rst_n(rst_n),
    .ticks(ticks),
    .sel  (ctrl_q[ESEL_LSB +: ESEL_W]),
    .count(up_count)
  );

  // Control word: a software write takes priority over the one-shot self-stop.
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = reg_wdata & CTRL_MASK;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        if (expire[i] && !ctrl_q[MODE_LSB+i]) ctrl_d[RUN_LSB+i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      irq_q  <= (irq_q & ~clr_mask) | expire;
    end
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFF_CTRL) reg_rdata = ctrl_q;
    else if (reg_addr == OFF_UP) reg_rdata = DATA_W'(up_count);
    else if (reg_addr == OFF_STAT) reg_rdata = DATA_W'(irq_q);
    else begin
      for (int i = 0; i < N_CH; i++) begin
        if (reg_addr == ch_offset(i)) reg_rdata = DATA_W'(count_w[i]);
      end
    end
  end
endmodule

// File: rtl/mc_timer_chk.sv
module mc_timer_chk
  import mc_timer_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int CNT_W   = 16,
  parameter int UP_W    = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic [N_CH-1:0]       irq,
  input logic [N_CH-1:0]       expire,
  input logic                  tick_us,
  input logic [DATA_W-1:0]     ctrl_q,
  input logic [UP_W-1:0]       up_count,
  input logic [N_CH*CNT_W-1:0] count_flat
);
  localparam int GAP_W = $clog2(CLK_MHZ + 1) + 1;

  logic             ctrl_wr;
  logic [N_CH-1:0]  clr_mask;
  logic [GAP_W-1:0] gap;
  logic             seen_tick;
  logic [2:0]       esel;

  assign ctrl_wr  = reg_wr && (reg_addr == OFF_CTRL);
  assign clr_mask = (reg_wr && (reg_addr == OFF_STAT)) ? reg_wdata[N_CH-1:0] : '0;
  assign esel     = ctrl_q[ESEL_LSB +: ESEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
      seen_tick <= 1'b0;
    end else if (tick_us) begin
      gap <= '0;
      seen_tick <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  // R2: microsecond ticks are evenly spaced
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_us && seen_tick) |-> (gap == GAP_W'(CLK_MHZ - 1)));

  // R5: a set interrupt only falls on a clear write
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq) & ~$past(clr_mask) & ~irq) == '0));

  // R3: an interrupt only rises after an expiry
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq & ~$past(irq) & ~$past(expire)) == '0));

  // R7: free-running selects step once per cycle
  p_up_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((esel == 3'd0) || (esel > 3'd4)) |=> (up_count == $past(up_count) + 1'b1));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    // R3: one-shot expiry drops the run bit
    p_oneshot_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && !ctrl_q[MODE_LSB+i] && !ctrl_wr) |=> !ctrl_q[RUN_LSB+i]);

    // R6: a stopped channel holds its count
    p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[RUN_LSB+i] && !ctrl_wr) |=> $stable(count_flat[i*CNT_W +: CNT_W]));

    // R6: no expiry while stopped
    p_no_expire_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |-> ctrl_q[RUN_LSB+i]);
  end
endmodule

bind mc_timer mc_timer_chk #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W), .UP_W(UP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .expire    (expire),
  .tick_us   (ticks[0]),
  .ctrl_q    (ctrl_q),
  .up_count  (up_count),
  .count_flat(count_flat)
);

// File: tb/sim_mc_timer.sv
`timescale 1ns/1ps
module sim_mc_timer;
  localparam int CLK_MHZ = 2;
  localparam int T1 = CLK_MHZ, T10 = 10 * T1, T100 = 100 * T1, T1MS = 1000 * T1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mc_timer #(.CLK_MHZ(CLK_MHZ), .CNT_W(16), .UP_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input string what, input longint act,
                           input longint lo, input longint hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v); check("R1", "ctrl after reset", v, 0);
    rd(5'h18, v); check("R1", "status after reset", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(5'(4 + 4 * i), v); check("R1", "count after reset", v, 0);
    end
    check("R1", "irq after reset", irq, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(5'h00, 32'hFFF0_FFFF);
    rd(5'h00, v); check("R9", "ctrl readback masks bits 11,31:20", v, 32'h0000_F7FF);
    wr(5'h00, 32'h0);
    rd(5'h00, v); check("R9", "ctrl cleared", v, 0);
  endtask

  task automatic e_rate(input logic [2:0] sel, input int cyc, input longint exp);
    logic [31:0] a, b;
    wr(5'h00, 32'(sel) << 8);
    rd(5'h14, a);
    repeat (cyc) @(negedge clk);
    rd(5'h14, b);
    check("R7", $sformatf("up-counter steps sel=%0d", sel), b - a, exp);
  endtask

  task automatic t_up_counter();
    logic [31:0] a, b;
    e_rate(3'd0, 50, 50);
    e_rate(3'd6, 50, 50);
    e_rate(3'd1, 100, 100 / T1);
    e_rate(3'd2, 200, 200 / T10);
    wr(5'h00, 32'h0);
    rd(5'h14, a);
    wr(5'h14, 32'h0);
    rd(5'h14, b);
    check("R8", "write to up-counter ignored", b - a, 1);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    int n;
    wr(5'h08, 32'd4);
    wr(5'h00, (32'h1 << 17) | (32'd0 << 2));
    check("R3", "irq low right after start", irq[1], 0);
    wait_irq(1, n);
    check_rng("R3", "one-shot latency cycles, N=4 at 1us", n, 4 * T1 + 1, 5 * T1);
    check("R10", "other irq lines stay low", irq & 4'b1101, 0);
    rd(5'h00, v); check("R3", "run bit self-cleared", v[17], 0);
    repeat (20) @(negedge clk);
    rd(5'h08, v); check("R3", "count held at 0", v, 0);
    check("R5", "irq level held", irq[1], 1);
    wr(5'h18, 32'h0);
    check("R5", "writing 0 keeps irq", irq[1], 1);
    wr(5'h18, 32'h2);
    check("R5", "writing 1 clears irq", irq[1], 0);
    rd(5'h18, v); check("R5", "status reads 0", v, 0);
  endtask

  task automatic measure_period(input int ch, input logic [1:0] sel, input int load,
                                input int exp, input string req);
    int n, m;
    wr(5'(4 + 4 * ch), 32'(load));
    wr(5'h00, (32'h1 << (16 + ch)) | (32'h1 << (12 + ch)) | (32'(sel) << (2 * ch)));
    wait_irq(ch, n);
    wr(5'h18, 32'h1 << ch);
    wait_irq(ch, m);
    check(req, $sformatf("periodic period ch=%0d sel=%0d", ch, sel), m + 1, exp);
  endtask

  task automatic t_periodic();
    measure_period(2, 2'd1, 2, 3 * T10, "R4");
    // collision: clear write completes on the next expiry edge
    repeat (3 * T10 - 1) @(negedge clk);
    wr(5'h18, 32'h4);
    check("R5", "expiry beats simultaneous clear", irq[2], 1);
    wr(5'h00, 32'h0);
    wr(5'h18, 32'hF);
    measure_period(0, 2'd2, 0, T100, "R2");
    wr(5'h00, 32'h0);
    wr(5'h18, 32'hF);
    measure_period(3, 2'd3, 0, T1MS, "R2");
    wr(5'h00, 32'h0);
    wr(5'h18, 32'hF);
    check("R5", "all cleared", irq, 0);
  endtask

  task automatic t_stop_restart();
    logic [31:0] a, b;
    int n;
    wr(5'h10, 32'd9);
    wr(5'h00, 32'h1 << 19);
    repeat (5) @(negedge clk);
    wr(5'h00, 32'h0);
    rd(5'h10, a);
    repeat (40) @(negedge clk);
    rd(5'h10, b);
    check("R6", "stopped count frozen", b, a);
    check_rng("R6", "stopped count nonzero", b, 1, 9);
    check("R6", "no irq while stopped", irq[3], 0);
    wr(5'h00, 32'h1 << 19);
    rd(5'h10, a);
    check("R6", "restart reloads value", a, 9);
    wait_irq(3, n);
    check_rng("R6", "restart latency cycles, N=9", n, 9 * T1 + 1, 10 * T1);
    wr(5'h18, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_up_counter();
    t_oneshot();
    t_periodic();
    t_stop_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule